// File: doc/BRIEF.md
# Multi-Channel Serial PCM Receive Deserializer

This block takes companded voice samples from a serial PCM port and turns them into parallel words, one per channel per frame. The bit clock, the receive frame sync and the data lanes come from outside. A system clock samples all of them, so the block watches for bit-clock edges rather than running on the bit clock itself. A layout input picks between two wirings. In the split layout every channel has its own data lane. In the chained layout lane 0 carries every channel's byte back to back, and the other lanes are ignored.

Each finished byte is presented on a parallel bus with a one-cycle strobe for its channel. The block also keeps a count of system-clock cycles since the most recent transmit-sync rising edge. Every byte latch is compared with a processing instant (`PROC_CNT` cycles after that edge). A latch that lands within `GUARD_CNT` cycles of the instant raises a slip warning in the same cycle as the strobe. Such a latch could lose a sample or repeat one downstream.

Top module: `pcm_rx_deser`

## Requirements
- R1: After reset `smp_vld_o`, `smp_data_o` and `slip_o` are all zero.
- R2: Data bits are sampled on bit-clock falling edges. The first falling edge that finds `rsync_i` high, after one that found it low, carries the first bit of the frame. Within each byte the first bit received becomes bit 7 of the word (MSB first).
- R3: With `layout_i` = 0 at frame start, lane c carries channel c's byte. All channel bytes are latched together and every bit of `smp_vld_o` is set. Channel c's byte appears on `smp_data_o[8c+7:8c]`.
- R4: With `layout_i` = 1 at frame start, lane 0 carries the channel bytes one after another in the order channel 0, 1, 2. Byte k is presented on `smp_data_o[8k+7:8k]` with only `smp_vld_o[k]` set. Lanes 1 and 2 have no effect.
- R5: A byte is latched at the bit-clock rising edge that follows its last bit. Its strobe and data appear at the first clock edge that samples `bclk_i` high after that bit, and the strobe lasts one cycle.
- R6: Bit-clock edges after the last byte of a frame produce nothing until the next frame sync.
- R7: A new sync rising edge that arrives before the frame is complete restarts alignment. The partial byte is discarded and never strobed.
- R8: The layout is captured at frame start. Changing `layout_i` during a frame does not alter that frame.
- R9: Let E be the number of clock edges from the edge that first samples `xsync_i` high to the edge that samples the latching bit-clock rise. `slip_o` is high with the strobe exactly when E lies within [PROC_CNT-GUARD_CNT, PROC_CNT+GUARD_CNT]. Before any transmit sync has been seen, it is never high.
- R10: The slip count restarts at every transmit-sync rising edge, so only the most recent one matters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the reference for the slip window |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| rsync_i | input | 1 | Receive frame sync, rising edge marks the first bit |
| xsync_i | input | 1 | Transmit frame sync, origin of the processing instant |
| layout_i | input | 1 | 0 = one lane per channel, 1 = all channels on lane 0 |
| lane_i | input | NCH | Serial data lanes |
| smp_vld_o | output | NCH | One-cycle strobe per channel byte |
| smp_data_o | output | NCH*WORD | Latched bytes, channel c in slice c |
| slip_o | output | 1 | Latch fell inside the guard window |

## Verification
The byte-latch strobe and the slip decision happen on the same clock edge, because the window comparison is made at the very bit-clock rise that latches the byte. The bench provokes this by firing a transmit sync and then delaying the receive frame so that the latching rise lands exactly on the window's outer edges and one cycle beyond each. It also lands a chained frame so that only its middle byte falls inside the window. The scoreboard predicts the slip bit of every byte from its own count of elapsed edges and compares it together with the data, the channel and the arrival cycle of the strobe.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   typedef enum logic {
      LAYOUT_SPLIT = 1'b0,
      LAYOUT_CHAIN = 1'b1
   } layout_e;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/pcm_rx_insync.sv
module pcm_rx_insync #(
   parameter int unsigned W      = 4,
   parameter int unsigned STAGES = 0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES == 0) begin : g_pass
      assign q_o = d_i;
   end else begin : g_flops
      logic [W-1:0] stg_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= '0;
         end else begin
            stg_q[0] <= d_i;
            for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
         end
      end
      assign q_o = stg_q[STAGES-1];
   end

endmodule

// File: rtl/pcm_rx_edges.sv
module pcm_rx_edges #(
   parameter int unsigned W = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);

   logic [W-1:0] lvl_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) lvl_q <= '0;
      else         lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
   assign fall_o = ~lvl_i & lvl_q;

endmodule

// File: rtl/pcm_rx_framer.sv
module pcm_rx_framer #(
   parameter int unsigned NCH  = 3,
   parameter int unsigned WORD = 8,
   localparam int unsigned SW  = pcm_rx_pkg::idx_width(NCH),
   localparam int unsigned BW  = pcm_rx_pkg::idx_width(WORD)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          bfall_i,
   input  logic          brise_i,
   input  logic          rsync_i,
   input  logic          layout_i,
   output logic          shift_o,
   output logic          chain_o,
   output logic          lat_o,
   output logic [SW-1:0] slot_o
);

   logic          rs_seen_q, run_q, chain_q, pend_q;
   logic [BW-1:0] bidx_q;
   logic [SW-1:0] sidx_q, pslot_q;
   logic          start_w, take_w, chain_w, byte_end_w, last_slot_w;

   assign start_w     = bfall_i & rsync_i & ~rs_seen_q;
   assign chain_w     = start_w ? layout_i : chain_q;
   assign take_w      = bfall_i & (start_w | run_q);
   assign byte_end_w  = (bidx_q == BW'(WORD - 1));
   assign last_slot_w = chain_w ? (sidx_q == SW'(NCH - 1)) : 1'b1;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rs_seen_q <= 1'b0;
         run_q     <= 1'b0;
         chain_q   <= 1'b0;
         pend_q    <= 1'b0;
         bidx_q    <= '0;
         sidx_q    <= '0;
         pslot_q   <= '0;
      end else begin
         if (bfall_i) rs_seen_q <= rsync_i;
         if (brise_i && pend_q) pend_q <= 1'b0;
         if (start_w) begin
            run_q   <= 1'b1;
            chain_q <= layout_i;
            bidx_q  <= BW'(1);
            sidx_q  <= '0;
         end else if (take_w) begin
            if (byte_end_w) begin
               bidx_q  <= '0;
               pend_q  <= 1'b1;
               pslot_q <= sidx_q;
               if (last_slot_w) run_q <= 1'b0;
               else             sidx_q <= sidx_q + SW'(1);
            end else begin
               bidx_q <= bidx_q + BW'(1);
            end
         end
      end
   end

   assign shift_o = take_w;
   assign chain_o = chain_w;
   assign lat_o   = brise_i & pend_q;
   assign slot_o  = pslot_q;

   // R7
   restart_no_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_w |=> !pend_q);

   // R3
   split_slot_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !chain_q |-> (sidx_q == '0));

endmodule

// File: rtl/pcm_rx_guard.sv
module pcm_rx_guard #(
   parameter int unsigned PROC_CNT  = 2539,
   parameter int unsigned GUARD_CNT = 50,
   localparam int unsigned TOPV = PROC_CNT + GUARD_CNT + 1,
   localparam int unsigned RW   = $clog2(TOPV + 1),
   localparam int unsigned LO   = PROC_CNT - GUARD_CNT,
   localparam int unsigned HI   = PROC_CNT + GUARD_CNT
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic xrise_i,
   output logic hit_o
);

   logic [RW-1:0] ref_q;
   logic          armed_q;
   logic [RW:0]   dist_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ref_q   <= '0;
         armed_q <= 1'b0;
      end else if (xrise_i) begin
         ref_q   <= '0;
         armed_q <= 1'b1;
      end else if (armed_q && ref_q != RW'(TOPV)) begin
         ref_q <= ref_q + RW'(1);
      end
   end

   assign dist_w = (RW+1)'(ref_q) + (RW+1)'(1);
   assign hit_o  = armed_q && (dist_w >= (RW+1)'(LO)) && (dist_w <= (RW+1)'(HI));

   // R10
   count_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_q <= RW'(TOPV));

endmodule

// File: rtl/pcm_rx_assemble.sv
module pcm_rx_assemble #(
   parameter int unsigned NCH  = 3,
   parameter int unsigned WORD = 8,
   localparam int unsigned SW  = pcm_rx_pkg::idx_width(NCH)
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                shift_i,
   input  logic [NCH-1:0]      lane_i,
   input  logic                lat_i,
   input  logic                chain_i,
   input  logic [SW-1:0]       slot_i,
   input  logic                hit_i,
   output logic [NCH-1:0]      vld_o,
   output logic [NCH*WORD-1:0] data_o,
   output logic                slip_o
);

   logic [NCH*WORD-1:0] sh_flat;
   logic [NCH-1:0]      vld_q;
   logic [NCH*WORD-1:0] data_q;
   logic                slip_q;

   for (genvar c = 0; c < int'(NCH); c++) begin : g_lane
      logic [WORD-1:0] sh_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)      sh_q <= '0;
         else if (shift_i) sh_q <= {sh_q[WORD-2:0], lane_i[c]};
      end
      assign sh_flat[c*WORD +: WORD] = sh_q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vld_q  <= '0;
         data_q <= '0;
         slip_q <= 1'b0;
      end else begin
         vld_q  <= '0;
         slip_q <= 1'b0;
         if (lat_i) begin
            slip_q <= hit_i;
            if (chain_i) begin
               if (int'(slot_i) < int'(NCH)) begin
                  vld_q[slot_i]                    <= 1'b1;
                  data_q[int'(slot_i)*WORD +: WORD] <= sh_flat[WORD-1:0];
               end
            end else begin
               vld_q  <= '1;
               data_q <= sh_flat;
            end
         end
      end
   end

   assign vld_o  = vld_q;
   assign data_o = data_q;
   assign slip_o = slip_q;

   // R5
   strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_q != '0) |=> (vld_q == '0));

   // R4
   chain_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      chain_i |-> $onehot0(vld_q));

   // R9
   slip_with_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slip_q |-> (vld_q != '0));

endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser #(
   parameter int unsigned NCH         = 3,
   parameter int unsigned WORD        = 8,
   parameter int unsigned PROC_CNT    = 2539,
   parameter int unsigned GUARD_CNT   = 50,
   parameter int unsigned SYNC_STAGES = 0,
   localparam int unsigned SW = pcm_rx_pkg::idx_width(NCH),
   localparam int unsigned IW = NCH + 4
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                bclk_i,
   input  logic                rsync_i,
   input  logic                xsync_i,
   input  logic                layout_i,
   input  logic [NCH-1:0]      lane_i,
   output logic [NCH-1:0]      smp_vld_o,
   output logic [NCH*WORD-1:0] smp_data_o,
   output logic                slip_o
);

   if (NCH < 1) begin : g_bad_nch
      $error("NCH must be at least 1");
   end
   if (WORD < 2) begin : g_bad_word
      $error("WORD must be at least 2");
   end
   if (GUARD_CNT > PROC_CNT) begin : g_bad_guard
      $error("GUARD_CNT must not exceed PROC_CNT");
   end
   if (SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must be 4 or less");
   end

   logic [IW-1:0]  raw_w, syn_w;
   logic           bclk_s, rsync_s, xsync_s, layout_s;
   logic [NCH-1:0] lane_s;
   logic [1:0]     rise_w, fall_w;
   logic           shift_w, chain_w, lat_w, hit_w;
   logic [SW-1:0]  slot_w;

   assign raw_w = {xsync_i, rsync_i, bclk_i, layout_i, lane_i};

   pcm_rx_insync #(.W(IW), .STAGES(SYNC_STAGES)) i_insync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_w),
      .q_o   (syn_w)
   );

   assign {xsync_s, rsync_s, bclk_s, layout_s, lane_s} = syn_w;

   pcm_rx_edges #(.W(2)) i_edges (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .lvl_i ({xsync_s, bclk_s}),
      .rise_o(rise_w),
      .fall_o(fall_w)
   );

   pcm_rx_framer #(.NCH(NCH), .WORD(WORD)) i_framer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .bfall_i (fall_w[0]),
      .brise_i (rise_w[0]),
      .rsync_i (rsync_s),
      .layout_i(layout_s),
      .shift_o (shift_w),
      .chain_o (chain_w),
      .lat_o   (lat_w),
      .slot_o  (slot_w)
   );

   pcm_rx_guard #(.PROC_CNT(PROC_CNT), .GUARD_CNT(GUARD_CNT)) i_guard (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .xrise_i(rise_w[1]),
      .hit_o  (hit_w)
   );

   pcm_rx_assemble #(.NCH(NCH), .WORD(WORD)) i_assemble (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(shift_w),
      .lane_i (lane_s),
      .lat_i  (lat_w),
      .chain_i(chain_w),
      .slot_i (slot_w),
      .hit_i  (hit_w),
      .vld_o  (smp_vld_o),
      .data_o (smp_data_o),
      .slip_o (slip_o)
   );

endmodule

// File: tb/test_pcm_rx_deser.sv
module test_pcm_rx_deser;

   localparam int NCH   = 3;
   localparam int WORD  = 8;
   localparam int PROC  = 200;
   localparam int GUARD = 10;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bclk = 1'b0, rsync = 1'b0, xsync = 1'b0, layout = 1'b0;
   logic [NCH-1:0]      lane = '0;
   logic [NCH-1:0]      vld;
   logic [NCH*WORD-1:0] data;
   logic                slip;

   pcm_rx_deser #(.NCH(NCH), .WORD(WORD), .PROC_CNT(PROC), .GUARD_CNT(GUARD)) i_pcm_rx_deser (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .bclk_i    (bclk),
      .rsync_i   (rsync),
      .xsync_i   (xsync),
      .layout_i  (layout),
      .lane_i    (lane),
      .smp_vld_o (vld),
      .smp_data_o(data),
      .slip_o    (slip)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct {
      int              chan;
      logic [WORD-1:0] data;
      bit              slip;
      int              cyc;
      string           req;
   } exp_t;

   exp_t  q[$];
   exp_t  mon_e;
   int    n_chk = 0, n_fail = 0;
   int    xs_cyc = 0;
   bit    xs_ok = 1'b0;
   string cur_req = "R2";

   task automatic push_exp(input int ch, input logic [WORD-1:0] d);
      int el;
      bit sl;
      el = cyc - xs_cyc;
      sl = xs_ok && (el >= PROC - GUARD) && (el <= PROC + GUARD);
      q.push_back('{ch, d, sl, cyc + 1, cur_req});
   endtask

   task automatic rise(input logic [NCH-1:0] d, input logic rs, input bit cont_now,
                       input int lat_byte, input logic [NCH*WORD-1:0] bytes);
      @(negedge clk);
      bclk  = 1'b1;
      lane  = d;
      rsync = rs;
      if (lat_byte >= 0) begin
         if (cont_now) push_exp(lat_byte, bytes[lat_byte*WORD +: WORD]);
         else for (int c = 0; c < NCH; c++) push_exp(c, bytes[c*WORD +: WORD]);
      end
      repeat (4) @(negedge clk);
      bclk = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic frame(input bit cont, input logic [NCH*WORD-1:0] bytes,
                        input int nbits, input int flip_at);
      int total;
      total  = cont ? NCH*WORD : WORD;
      layout = cont;
      for (int i = 0; i <= nbits; i++) begin
         logic [NCH-1:0] d;
         int lb;
         if (i == nbits && nbits < total) break;
         for (int c = 0; c < NCH; c++) begin
            if (i >= total)   d[c] = 1'($urandom);
            else if (cont)    d[c] = (c == 0) ? bytes[(i/WORD)*WORD + WORD-1 - (i%WORD)] : 1'($urandom);
            else              d[c] = bytes[c*WORD + WORD-1 - i];
         end
         lb = (i > 0 && (i % WORD) == 0) ? i/WORD - 1 : -1;
         if (flip_at >= 0 && i == flip_at) layout = ~cont;
         rise(d, (i == 0), cont, lb, bytes);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) rise(NCH'($urandom), 1'b0, 1'b0, -1, '0);
   endtask

   task automatic xs_pulse();
      @(negedge clk);
      xsync  = 1'b1;
      xs_cyc = cyc;
      xs_ok  = 1'b1;
      repeat (2) @(negedge clk);
      xsync = 1'b0;
   endtask

   task automatic at_offset(input int off);
      while (cyc < xs_cyc + off - 1) @(negedge clk);
   endtask

   // monitor: pops the scoreboard whenever a strobe appears
   always @(negedge clk) begin
      if (rst_n) begin
         if (vld != '0) begin
            for (int c = 0; c < NCH; c++) begin
               if (vld[c]) begin
                  n_chk++;
                  if (q.size() == 0) begin
                     n_fail++;
                     $display("FAIL R6/R7 unexpected strobe ch %0d: got data %h, expected no strobe",
                              c, data[c*WORD +: WORD]);
                  end else begin
                     mon_e = q.pop_front();
                     if (mon_e.chan != c || mon_e.data != data[c*WORD +: WORD] ||
                         mon_e.slip != slip || mon_e.cyc != cyc) begin
                        n_fail++;
                        $display("FAIL %s: got ch %0d data %h slip %0b cyc %0d, expected ch %0d data %h slip %0b cyc %0d",
                                 mon_e.req, c, data[c*WORD +: WORD], slip, cyc,
                                 mon_e.chan, mon_e.data, mon_e.slip, mon_e.cyc);
                     end
                  end
               end
            end
         end else if (slip) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 slip without strobe: got 1, expected 0");
         end
      end
   end

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      n_chk++;
      if (vld != '0 || data != '0 || slip != 1'b0) begin
         n_fail++;
         $display("FAIL R1 reset state: got vld %b data %h slip %0b, expected 0 0 0", vld, data, slip);
      end

      cur_req = "R2";  frame(1'b0, 24'h1E_C4_B7, 8, -1);
      cur_req = "R6";  idle(3);
      cur_req = "R3";  frame(1'b0, 24'h00_FF_6A, 8, -1);
      frame(1'b0, 24'h80_01_D3, 8, -1);
      idle(2);
      cur_req = "R4";  frame(1'b1, 24'h5A_0F_E1, 24, -1);
      cur_req = "R6";  idle(4);
      cur_req = "R4";  frame(1'b1, 24'h01_80_C6, 24, -1);
      idle(2);
      cur_req = "R7";  frame(1'b0, 24'hFF_FF_FF, 5, -1);
      frame(1'b0, 24'h27_93_4D, 8, -1);
      frame(1'b1, 24'hAA_BB_3C, 13, -1);
      frame(1'b1, 24'h12_34_56, 24, -1);
      idle(2);
      cur_req = "R8";  frame(1'b1, 24'h9C_63_F0, 24, 5);
      frame(1'b0, 24'h71_E8_2B, 8, 4);
      idle(2);

      // R9: latch exactly at window edges and one step outside
      cur_req = "R9";
      xs_pulse(); at_offset(PROC + GUARD - 64);     frame(1'b0, 24'h11_22_33, 8, -1); idle(1);
      xs_pulse(); at_offset(PROC + GUARD + 1 - 64); frame(1'b0, 24'h44_55_66, 8, -1); idle(1);
      xs_pulse(); at_offset(PROC - GUARD - 64);     frame(1'b0, 24'h77_88_99, 8, -1); idle(1);
      xs_pulse(); at_offset(PROC - GUARD - 1 - 64); frame(1'b0, 24'hCA_FE_0B, 8, -1); idle(1);
      xs_pulse(); at_offset(PROC - 128);            frame(1'b1, 24'hD1_E2_F3, 24, -1); idle(1);
      // R10: second sync restarts the count
      cur_req = "R10";
      xs_pulse(); repeat (100) @(negedge clk);
      xs_pulse(); at_offset(PROC + 5 - 64);         frame(1'b0, 24'h3E_5D_7C, 8, -1); idle(2);

      repeat (5) @(negedge clk);
      // R5: every predicted strobe arrived
      n_chk++;
      if (q.size() != 0) begin
         n_fail++;
         $display("FAIL R5 missing strobes: got %0d outstanding, expected 0", q.size());
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R5 watchdog: got no completion, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule